// File: doc/BRIEF.md
# Memory-Controller Performance Counter Bank

This block is a set of performance counters that sits beside a DDR memory controller. Software configures and reads it over a small single-cycle register bus. Slot 0 is a free-running cycle counter. The remaining slots each count one controller event. The event is picked by an 8-bit code that indexes a vector of one-cycle event pulses driven by the controller.

The cycle counter governs the whole bank. While it is disabled, or after it has wrapped, no counter advances. Its wrap also raises a level interrupt, which software services by reading all counts and then restarting the bank. An event counter that wraps only latches its own sticky overflow flag and stops. The clear bit acts on a rising write for the cycle counter. For an event counter it acts on a written zero, and it always reads back as one.

Top module: `memctl_perfmon`

## Requirements
- R1: After reset every count reads 0, the control word of slot 0 reads 0x00000000, the control word of each event slot reads 0x00000002 (clear bit reads 1), and irq is low.
- R2: The control word of slot n is at address 4*n and its count is at 0x20+4*n. Control fields: bit 0 overflow (read-only), bit 1 clear, bit 2 enable, bits 31:24 event code. Read data is registered and appears in the cycle after the read strobe. It is zero in any cycle that follows no read, and any address outside the map, or not word aligned, reads 0.
- R3: While enabled and not overflowed, slot 0 adds one on every clock edge. Its event-code field is ignored on write and reads 0.
- R4: An enabled event slot adds one on each clock edge where the event line indexed by its code is high. Code 0 and codes at or above the number of event lines count nothing.
- R5: While slot 0's enable bit is low, no event slot advances. Setting the bit again lets them resume.
- R6: When slot 0 counts past all ones it wraps to 0, sets its overflow bit and drives irq high, and from then on every counter holds its value.
- R7: irq is a level that stays high until a write to slot 0's control word sets the clear bit while its stored clear bit is 0. Writing the clear bit as 0, or as 1 while it is already stored as 1, leaves irq and the count unchanged. A clear sets the count to 0 and drops irq.
- R8: When an event slot counts past all ones it wraps to 0, sets its sticky overflow bit and stops counting, and irq is not affected.
- R9: Writing an event slot's control word with the clear bit 0 sets its count to 0 and drops its overflow bit, and the clear bit reads back as 1. Writing it with the clear bit 1 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| evt_lines | input | EVT_LINES | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Level interrupt, high after a cycle-counter wrap |

## Verification
The main stimulus is a table of event-code assignments for the three event slots, combined with bursts of pulses of different lengths on two distinct event lines. This shows that each slot follows only its own code. The table includes two slots sharing one code, a slot whose code is not pulsed, a pulsed line 0, and a code above the line count, which separate correct indexing from aliasing or stray counting. Directed runs with a reduced counter width drive the cycle counter and one event counter through their wraps. They show that the global freeze differs from the local stop and that the interrupt clears only on a rising clear write.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int REG_W   = 32;
    localparam int OVF_BIT = 0;
    localparam int CLR_BIT = 1;
    localparam int EN_BIT  = 2;
    localparam int SEL_LSB = 24;
    localparam int SEL_W   = 8;

    // address bits [7:5] pick the bank, [4:2] the slot
    localparam logic [2:0] BANK_CTRL = 3'b000;
    localparam logic [2:0] BANK_CNT  = 3'b001;

    function automatic logic [REG_W-1:0] pack_ctrl(
        input logic             ovf,
        input logic             clr,
        input logic             en,
        input logic [SEL_W-1:0] sel
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[OVF_BIT] = ovf;
        w[CLR_BIT] = clr;
        w[EN_BIT]  = en;
        w[SEL_LSB +: SEL_W] = sel;
        return w;
    endfunction

endpackage

// File: rtl/perfmon_evt_sel.sv
module perfmon_evt_sel
    import perfmon_pkg::*;
#(
    parameter int EVT_LINES = 64
) (
    input  logic [EVT_LINES-1:0] lines,
    input  logic [SEL_W-1:0]     sel,
    output logic                 hit
);
    localparam int IDX_W = $clog2(EVT_LINES);

    logic in_range;

    // code 0 belongs to the cycle slot; codes past the vector see nothing
    assign in_range = (sel != '0) && (int'(sel) < EVT_LINES);
    assign hit      = in_range && lines[sel[IDX_W-1:0]];

endmodule

// File: rtl/perfmon_ctr.sv
module perfmon_ctr
    import perfmon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hit,
    input  logic             gate,
    output logic [CNT_W-1:0] cnt_o,
    output logic [REG_W-1:0] ctrl_o,
    output logic             ovf_o,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             clr;
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    logic             clear_hit;
    logic             clr_next;
    logic [SEL_W-1:0] sel_next;
    logic             inc;
    logic [CNT_W:0]   sum_ext;
    logic             unused_wr;

    assign unused_wr = ^{wr_data[REG_W-1:SEL_LSB], wr_data[SEL_LSB-1:EN_BIT+1], wr_data[OVF_BIT]};

    generate
        if (IS_CYCLE) begin : g_cyc
            // rising edge of the stored clear bit
            assign clear_hit = wr_en && wr_data[CLR_BIT] && !st_q.clr;
            assign clr_next  = wr_data[CLR_BIT];
            assign sel_next  = '0;
        end else begin : g_evt
            // a written zero clears; the bit springs back to one
            assign clear_hit = wr_en && !wr_data[CLR_BIT];
            assign clr_next  = 1'b1;
            assign sel_next  = wr_data[SEL_LSB +: SEL_W];
        end
    endgenerate

    assign inc     = st_q.en && gate && hit && !st_q.ovf;
    assign sum_ext = {1'b0, st_q.cnt} + (CNT_W+1)'(1);

    always_comb begin
        st_d = st_q;
        if (inc) begin
            st_d.cnt = sum_ext[CNT_W-1:0];
            if (sum_ext[CNT_W]) begin
                st_d.ovf = 1'b1;
            end
        end
        if (wr_en) begin
            st_d.en  = wr_data[EN_BIT];
            st_d.clr = clr_next;
            st_d.sel = sel_next;
        end
        if (clear_hit) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.ovf <= 1'b0;
            st_q.clr <= !IS_CYCLE;
            st_q.en  <= 1'b0;
            st_q.sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign ovf_o  = st_q.ovf;
    assign en_o   = st_q.en;
    assign sel_o  = st_q.sel;
    assign ctrl_o = pack_ctrl(st_q.ovf, st_q.clr, st_q.en, st_q.sel);

endmodule

// File: rtl/memctl_perfmon.sv
module memctl_perfmon
    import perfmon_pkg::*;
#(
    parameter int NCNT      = 4,
    parameter int CNT_W     = 32,
    parameter int EVT_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic                 reg_re,
    input  logic [7:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [EVT_LINES-1:0] evt_lines,
    output logic                 irq
);
    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } bus_state_t;

    bus_state_t bus_d, bus_q;

    logic [CNT_W-1:0]      cnt_w  [NCNT];
    logic [REG_W-1:0]      ctrl_w [NCNT];
    logic [SEL_W-1:0]      sel_w  [NCNT];
    logic [NCNT-1:0]       ovf_vec;
    logic [NCNT-1:0]       en_vec;
    logic [NCNT*CNT_W-1:0] cnt_flat;
    logic                  cyc_en;
    logic                  aligned;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign cyc_en  = en_vec[0];
    assign irq     = ovf_vec[0];

    for (genvar n = 0; n < NCNT; n++) begin : g_slot
        logic hit_n;
        logic gate_n;
        logic wr_n;

        assign wr_n = reg_we && aligned && (reg_addr[7:5] == BANK_CTRL) &&
                      (reg_addr[4:2] == 3'(n));

        if (n == 0) begin : g_cyc
            assign hit_n  = 1'b1;
            assign gate_n = 1'b1;
        end else begin : g_evt
            perfmon_evt_sel #(.EVT_LINES(EVT_LINES)) u_sel (
                .lines (evt_lines),
                .sel   (sel_w[n]),
                .hit   (hit_n)
            );
            // the cycle slot is the master run control
            assign gate_n = cyc_en && !irq;
        end

        perfmon_ctr #(.CNT_W(CNT_W), .IS_CYCLE(n == 0)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_n),
            .wr_data (reg_wdata),
            .hit     (hit_n),
            .gate    (gate_n),
            .cnt_o   (cnt_w[n]),
            .ctrl_o  (ctrl_w[n]),
            .ovf_o   (ovf_vec[n]),
            .en_o    (en_vec[n]),
            .sel_o   (sel_w[n])
        );

        assign cnt_flat[n*CNT_W +: CNT_W] = cnt_w[n];
    end

    always_comb begin
        bus_d.rdata = '0;
        if (reg_re && aligned) begin
            for (int n = 0; n < NCNT; n++) begin
                if (reg_addr[4:2] == 3'(n)) begin
                    if (reg_addr[7:5] == BANK_CTRL) begin
                        bus_d.rdata = ctrl_w[n];
                    end else if (reg_addr[7:5] == BANK_CNT) begin
                        bus_d.rdata = REG_W'(cnt_w[n]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q.rdata <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign reg_rdata = bus_q.rdata;

endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk #(
    parameter int NCNT  = 4,
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic                  reg_re,
    input logic [7:0]            reg_addr,
    input logic [31:0]           reg_rdata,
    input logic                  irq,
    input logic                  cyc_en,
    input logic [NCNT-1:0]       ovf_vec,
    input logic [NCNT*CNT_W-1:0] cnt_flat
);
    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> reg_rdata == 32'h0);

    // R6
    irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt_flat[CNT_W-1:0] == '0) && (&$past(cnt_flat[CNT_W-1:0])));

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !reg_we |=> $stable(cnt_flat));

    // R5
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en && !reg_we |=> $stable(cnt_flat[NCNT*CNT_W-1:CNT_W]));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !reg_we |=> irq);

    for (genvar n = 1; n < NCNT; n++) begin : g_evt_chk
        // R8
        evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_vec[n] && !(reg_we && reg_addr == 8'(4*n)) |=> ovf_vec[n]);

        // R8
        evt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_vec[n] && !reg_we |=> $stable(cnt_flat[n*CNT_W +: CNT_W]));
    end

endmodule

bind memctl_perfmon perfmon_chk #(.NCNT(NCNT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .cyc_en    (cyc_en),
    .ovf_vec   (ovf_vec),
    .cnt_flat  (cnt_flat)
);

// File: tb/memctl_perfmon_tb.sv
`timescale 1ns/1ps
module memctl_perfmon_tb;

    localparam int LINES = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic             reg_re = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [LINES-1:0] evt = '0;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    memctl_perfmon #(.NCNT(4), .CNT_W(8), .EVT_LINES(LINES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_lines (evt),
        .irq       (irq)
    );

    // {code1, code2, code3, lineA, countA, lineB, countB}
    localparam logic [55:0] VEC [6] = '{
        {8'h04, 8'h05, 8'h20, 8'h04, 8'd10, 8'h05, 8'd3},
        {8'h20, 8'h21, 8'h31, 8'h21, 8'd7,  8'h31, 8'd12},
        {8'h32, 8'h32, 8'h37, 8'h32, 8'd20, 8'h37, 8'd1},
        {8'h00, 8'h04, 8'h05, 8'h00, 8'd9,  8'h04, 8'd4},
        {8'h80, 8'h3F, 8'h01, 8'h3F, 8'd15, 8'h01, 8'd2},
        {8'h05, 8'h04, 8'h21, 8'h04, 8'd30, 8'h05, 8'd30}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input int line, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            evt = '0;
            evt[line[5:0]] = 1'b1;
            @(negedge clk);
        end
        evt = '0;
    endtask

    function automatic logic [31:0] expect_slot(input logic [7:0] code, input logic [7:0] la,
                                                input logic [7:0] ca, input logic [7:0] lb,
                                                input logic [7:0] cb);
        if (code == 8'h00 || int'(code) >= LINES) return 32'd0;
        if (code == la) return 32'(ca);
        if (code == lb) return 32'(cb);
        return 32'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        rd(8'h00, v); check("R1 ctrl0", v, 32'h0);
        rd(8'h04, v); check("R1 ctrl1", v, 32'h2);
        rd(8'h0C, v); check("R1 ctrl3", v, 32'h2);
        rd(8'h20, v); check("R1 cnt0", v, 32'h0);
        rd(8'h2C, v); check("R1 cnt3", v, 32'h0);

        // R2 unmapped and misaligned reads, idle bus
        rd(8'h10, v); check("R2 slot4 ctrl", v, 32'h0);
        rd(8'h40, v); check("R2 bank2", v, 32'h0);
        rd(8'h06, v); check("R2 misaligned", v, 32'h0);
        @(negedge clk);
        check("R2 idle rdata", reg_rdata, 32'h0);

        // R3 cycle count: clear edge, one read edge, 20 idle, disable edge -> 22
        wr(8'h00, 32'h0);
        wr(8'h00, 32'hFF00_0006);
        rd(8'h00, v); check("R3 ctrl0 code ignored", v, 32'h0000_0006);
        repeat (20) @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h20, v); check("R3 cycle count", v, 32'd22);

        // R4 table of code assignments and pulse bursts
        for (int k = 0; k < 6; k++) begin
            logic [7:0] c1, c2, c3, la, ca, lb, cb;
            int mx;
            {c1, c2, c3, la, ca, lb, cb} = VEC[k];
            wr(8'h00, 32'h0);
            wr(8'h04, {c1, 24'h000004});
            wr(8'h08, {c2, 24'h000004});
            wr(8'h0C, {c3, 24'h000004});
            wr(8'h00, 32'h6);
            mx = (int'(ca) > int'(cb)) ? int'(ca) : int'(cb);
            for (int i = 0; i < mx; i++) begin
                evt = '0;
                if (i < int'(ca)) evt[la[5:0]] = 1'b1;
                if (i < int'(cb)) evt[lb[5:0]] = 1'b1;
                @(negedge clk);
            end
            evt = '0;
            wr(8'h00, 32'h0);
            rd(8'h24, v); check($sformatf("R4 entry %0d slot1", k), v, expect_slot(c1, la, ca, lb, cb));
            rd(8'h28, v); check($sformatf("R4 entry %0d slot2", k), v, expect_slot(c2, la, ca, lb, cb));
            rd(8'h2C, v); check($sformatf("R4 entry %0d slot3", k), v, expect_slot(c3, la, ca, lb, cb));
        end

        // R9 clear bit semantics on an event slot (slot1 holds 30, code 0x05)
        wr(8'h04, 32'h0500_0006);
        rd(8'h24, v); check("R9 clr=1 keeps count", v, 32'd30);
        wr(8'h04, 32'h0500_0004);
        rd(8'h24, v); check("R9 clr=0 clears", v, 32'd0);
        rd(8'h04, v); check("R9 clr reads 1", v, 32'h0500_0006);

        // R5 freeze while cycle slot disabled, then resume
        pulse(5, 10);
        rd(8'h24, v); check("R5 frozen", v, 32'd0);
        wr(8'h00, 32'h4);
        pulse(5, 5);
        wr(8'h00, 32'h0);
        rd(8'h24, v); check("R5 resumed", v, 32'd5);

        // R8 event slot wrap at 8 bits, cycle slot restarted midway
        wr(8'h04, 32'h0400_0004);
        wr(8'h00, 32'h6);
        pulse(4, 200);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h6);
        pulse(4, 56);
        pulse(4, 3);
        rd(8'h24, v); check("R8 wrapped and stopped", v, 32'd0);
        rd(8'h04, v); check("R8 sticky overflow", v, 32'h0400_0007);
        check("R8 no irq", 32'(irq), 32'd0);
        wr(8'h04, 32'h0400_0004);
        rd(8'h04, v); check("R9 overflow cleared", v, 32'h0400_0006);
        pulse(4, 2);
        rd(8'h24, v); check("R9 counts again", v, 32'd2);

        // R6 cycle wrap freezes the bank and raises irq
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h2000_0004);
        wr(8'h00, 32'h6);
        pulse(32, 100);
        repeat (200) @(negedge clk);
        check("R6 irq high", 32'(irq), 32'd1);
        pulse(32, 10);
        rd(8'h20, v); check("R6 cycle wrapped", v, 32'd0);
        rd(8'h28, v); check("R6 event frozen", v, 32'd100);
        rd(8'h00, v); check("R6 ctrl0 overflow", v, 32'h0000_0007);

        // R7 only a rising clear write drops irq
        wr(8'h00, 32'h6);
        check("R7 repeated clr=1 keeps irq", 32'(irq), 32'd1);
        wr(8'h00, 32'h0);
        check("R7 clr=0 keeps irq", 32'(irq), 32'd1);
        rd(8'h20, v); check("R7 count held", v, 32'd0);
        wr(8'h00, 32'h6);
        check("R7 rising clr drops irq", 32'(irq), 32'd0);
        rd(8'h00, v); check("R7 ctrl0 after clear", v, 32'h0000_0006);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule